// File: doc/BRIEF.md
# Three-Level Channel Service Scheduler

This block decides which of sixteen identical timer channels is handed to a single shared service engine next. Every channel carries a 2-bit priority code and can raise a service request, either from its own logic or through a link request sent by another channel. Requests are latched as pending. Whenever the engine has no service outstanding, the scheduler picks one pending channel and raises a grant that carries the channel index. The grant stays up until the engine pulses done.

The highest active level always wins. Within one level, the choice rotates. Each level has its own pointer that moves to one past the last channel granted at that level. As a result, the lowest-numbered requester goes first, and the other waiting channels of that level follow in ascending order, wrapping from 15 to 0, before the first channel is served again. No single busy channel can starve its peers.

Top module: `svc_sched`

## Requirements
- R1: After reset, grantValid is 0, no request is pending, and every level's rotation pointer points at channel 0.
- R2: Channel i takes its priority from prioIn[2i+1:2i], where 01 is low, 10 is middle and 11 is high. A channel whose code is 00 is never granted, even when it has a request pending.
- R3: When a decision is made, a pending channel at a higher level always wins over any pending channel at a lower level.
- R4: Starting from reset, if several channels of one level are pending at the same time, the lowest-numbered one is granted first.
- R5: After a grant at a level, that level's next search starts one channel past the winner and wraps from channel 15 to channel 0. The other pending channels of the level are therefore served in ascending order before the winner is served again.
- R6: A decision is made only while no grant is outstanding. grantValid and grantIdx hold steady until a done pulse arrives. grantValid falls on the edge that samples done, and the next grant can appear no earlier than the following edge.
- R7: A channel's pending request is cleared on the edge that grants it. A request that arrives while a service is in progress, including one for the channel being served, stays pending until that channel is granted.
- R8: linkValid with linkTarget = t acts as a request on channel t. A link request and a reqIn request to the same channel in the same cycle merge into one pending request, which is served once.
- R9: A request sampled on edge t, with the engine idle, produces a grant visible after edge t+1. After edge t alone, grantValid is still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| prioIn | input | 32 | Two-bit priority code for each channel; channel i uses bits 2i+1:2i |
| reqIn | input | 16 | Request pulses, one bit per channel |
| linkValid | input | 1 | A link request is present this cycle |
| linkTarget | input | 4 | Index of the channel the link request targets |
| doneIn | input | 1 | Pulse from the engine that ends the current service |
| grantValid | output | 1 | A service is granted and outstanding |
| grantIdx | output | 4 | Index of the granted channel |

## Verification
Any fault in the internal state of this block shows up in the order of grants, and it shows up within a grant or two. If a rotation pointer is off, the wrong channel of a level wins at the very next decision at that level. If a pending bit is lost or duplicated, a channel is skipped or served twice, and this is visible as soon as the queue drains. A fault in the busy flag shows at once as a grant index that changes mid-service, or as a grant that never drops after done. The checks therefore compare whole grant sequences channel by channel, and they sample grantValid on the exact edges around done and around a new request.

// File: rtl/svc_sched_pkg.sv
package svc_sched_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic take;  // latch the winner, clear its pending bit, advance its level pointer
    logic busy;  // a grant is outstanding
  } sched_ctl_t;
endpackage

// File: rtl/svc_sched_ctrl.sv
module svc_sched_ctrl
  import svc_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       doneIn,
  input  logic       anyReady,
  output sched_ctl_t ctl
);
  logic busyQ;
  logic takeNow;

  assign takeNow = !busyQ && anyReady;

  always_ff @(posedge clk) begin
    if (!rstN)                 busyQ <= 1'b0;
    else if (takeNow)          busyQ <= 1'b1;
    else if (busyQ && doneIn)  busyQ <= 1'b0;
  end

  always_comb begin
    ctl.take = takeNow;
    ctl.busy = busyQ;
  end

  // R6: an outstanding grant persists until done
  assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && !doneIn |=> busyQ);
  // R6: done releases the grant on the next edge
  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && doneIn |=> !busyQ);
  // R9: a ready request while idle produces a grant one edge later
  assert_idle_take_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ && anyReady |=> busyQ);
endmodule

// File: rtl/svc_sched_dp.sv
module svc_sched_dp
  import svc_sched_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int PRIO_W = 2,
  localparam int IDX_W = $clog2(N_CH),
  localparam int N_LVL = 1 << PRIO_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PRIO_W*N_CH-1:0]  prioIn,
  input  logic [N_CH-1:0]         reqIn,
  input  logic                    linkValid,
  input  logic [IDX_W-1:0]        linkTarget,
  input  sched_ctl_t              ctl,
  output logic                    anyReady,
  output logic [IDX_W-1:0]        grantIdx
);
  logic [PRIO_W-1:0] prioCh [N_CH];
  logic [N_CH-1:0]   linkVec;
  logic [N_CH-1:0]   arrive;
  logic [N_CH-1:0]   pendQ;
  logic [N_CH-1:0]   clrVec;
  logic [IDX_W-1:0]  ptrQ   [1:N_LVL-1];
  logic [N_CH-1:0]   lvlMask [1:N_LVL-1];
  logic              lvlHit [1:N_LVL-1];
  logic [IDX_W-1:0]  lvlIdx [1:N_LVL-1];
  logic [PRIO_W-1:0] winLvl;
  logic [IDX_W-1:0]  winIdx;
  logic [IDX_W-1:0]  grantIdxQ;

  // rotating search: first set bit at or after start, wrapping
  function automatic logic [IDX_W:0] pickRot(input logic [N_CH-1:0] mask,
                                             input logic [IDX_W-1:0] start);
    logic             hit;
    logic [IDX_W-1:0] idx;
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N_CH; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= N_CH) j = j - N_CH;
      if (!hit && mask[j]) begin
        hit = 1'b1;
        idx = IDX_W'(j);
      end
    end
    return {hit, idx};
  endfunction

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    assign prioCh[i]  = prioIn[PRIO_W*i +: PRIO_W];
    assign linkVec[i] = linkValid && (linkTarget == IDX_W'(i));
    assign clrVec[i]  = ctl.take && (winIdx == IDX_W'(i));
  end

  assign arrive = reqIn | linkVec;

  // a fresh arrival wins over the clear of the same edge
  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrVec) | arrive;
  end

  for (genvar l = 1; l < N_LVL; l++) begin : g_lvl
    for (genvar i = 0; i < N_CH; i++) begin : g_bit
      assign lvlMask[l][i] = pendQ[i] && (prioCh[i] == PRIO_W'(l));
    end
    assign {lvlHit[l], lvlIdx[l]} = pickRot(lvlMask[l], ptrQ[l]);

    always_ff @(posedge clk) begin
      if (!rstN)
        ptrQ[l] <= '0;
      else if (ctl.take && winLvl == PRIO_W'(l))
        ptrQ[l] <= (winIdx == IDX_W'(N_CH-1)) ? '0 : winIdx + 1'b1;
    end
  end

  // highest level with a candidate wins
  always_comb begin
    winLvl   = '0;
    winIdx   = '0;
    anyReady = 1'b0;
    for (int l = N_LVL-1; l >= 1; l--) begin
      if (!anyReady && lvlHit[l]) begin
        anyReady = 1'b1;
        winLvl   = PRIO_W'(l);
        winIdx   = lvlIdx[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         grantIdxQ <= '0;
    else if (ctl.take) grantIdxQ <= winIdx;
  end
  assign grantIdx = grantIdxQ;

  // R6: index stays fixed while a grant is outstanding
  assert_idx_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |=> (!ctl.busy || $stable(grantIdxQ)));
  // R7: the winner must be a pending channel
  assert_win_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> pendQ[winIdx]);
  // R7: a granted request is cleared unless it re-arrived that cycle
  assert_clear_on_take_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take && !arrive[winIdx] |=> !pendQ[$past(winIdx)]);
  // R2: a disabled channel is never selected
  assert_no_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> prioCh[winIdx] != '0);
endmodule

// File: rtl/svc_sched.sv
module svc_sched
  import svc_sched_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int PRIO_W = 2,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PRIO_W*N_CH-1:0] prioIn,
  input  logic [N_CH-1:0]        reqIn,
  input  logic                   linkValid,
  input  logic [IDX_W-1:0]       linkTarget,
  input  logic                   doneIn,
  output logic                   grantValid,
  output logic [IDX_W-1:0]       grantIdx
);
  sched_ctl_t ctl;
  logic       anyReady;

  svc_sched_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .doneIn   (doneIn),
    .anyReady (anyReady),
    .ctl      (ctl)
  );

  svc_sched_dp #(.N_CH(N_CH), .PRIO_W(PRIO_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .prioIn     (prioIn),
    .reqIn      (reqIn),
    .linkValid  (linkValid),
    .linkTarget (linkTarget),
    .ctl        (ctl),
    .anyReady   (anyReady),
    .grantIdx   (grantIdx)
  );

  assign grantValid = ctl.busy;
endmodule

// File: tb/svc_sched_tb_top.sv
module svc_sched_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] prioIn = '0;
  logic [15:0] reqIn = '0;
  logic        linkValid = 1'b0;
  logic [3:0]  linkTarget = '0;
  logic        doneIn = 1'b0;
  logic        grantValid;
  logic [3:0]  grantIdx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  svc_sched dut_i (
    .clk(clk), .rstN(rstN), .prioIn(prioIn), .reqIn(reqIn),
    .linkValid(linkValid), .linkTarget(linkTarget), .doneIn(doneIn),
    .grantValid(grantValid), .grantIdx(grantIdx)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {prio[31:0], req[15:0], expected first grant[3:0]}  (R2, R3, R4)
  localparam logic [51:0] VEC [8] = '{
    {32'h5555_5555, 16'h8421, 4'd0},   // R4 lowest of equal level
    {32'h5555_5555, 16'h8420, 4'd5},   // R4
    {32'h5555_D555, 16'h8481, 4'd7},   // R3 high ch7 beats low
    {32'h555D_5565, 16'h0205, 4'd9},   // R3 high over mid over low
    {32'h555D_5565, 16'h0005, 4'd2},   // R3 mid over low
    {32'h4000_0000, 16'hFFFF, 4'd15},  // R2 only ch15 enabled
    {32'h0000_0100, 16'h0011, 4'd4},   // R2 ch0 disabled
    {32'hAAAA_AAA9, 16'h0003, 4'd1}    // R3 mid ch1 beats low ch0
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqIn = '0; linkValid = 1'b0; doneIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // request visible as pending after the next edge
  task automatic pulse(input logic [15:0] mask);
    reqIn = mask;
    @(negedge clk);
    reqIn = '0;
  endtask

  // check current grant, end it, advance to where the next grant shows
  task automatic serveOne(input int exp, input string tag);
    chk(grantValid === 1'b1, {tag, " valid"}, int'(grantValid), 1);
    chk(grantIdx == 4'(exp), {tag, " idx"}, int'(grantIdx), exp);
    doneIn = 1'b1;
    @(negedge clk);
    doneIn = 1'b0;
    chk(grantValid === 1'b0, {tag, " drop R6"}, int'(grantValid), 0);
    @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    doReset();
    chk(grantValid === 1'b0, "R1 reset grant", int'(grantValid), 0);
    prioIn = 32'h5555_5555;
    repeat (3) @(negedge clk);
    chk(grantValid === 1'b0, "R1 no pending", int'(grantValid), 0);

    // vector table
    for (int v = 0; v < 8; v++) begin
      doReset();
      prioIn = VEC[v][51:20];
      pulse(VEC[v][19:4]);
      @(negedge clk);
      serveOne(int'(VEC[v][3:0]), "R3/R4 table");
    end
    // last table entries leave disabled pending: R2 nothing granted
    doReset();
    prioIn = 32'h4000_0000;
    pulse(16'hFFFF);
    @(negedge clk);
    serveOne(15, "R2 enabled only");
    repeat (3) @(negedge clk);
    chk(grantValid === 1'b0, "R2 disabled never granted", int'(grantValid), 0);

    // R5 rotation, R7 held pending, R9 timing, R6 hold
    doReset();
    prioIn = 32'h5555_5555;
    pulse(16'h0222);
    chk(grantValid === 1'b0, "R9 not yet granted", int'(grantValid), 0);
    @(negedge clk);
    chk(grantValid === 1'b1 && grantIdx == 4'd1, "R9 grant after two edges", int'(grantIdx), 1);
    pulse(16'h0002);  // R7 ch1 again during its own service
    pulse(16'h0000);
    repeat (3) @(negedge clk);
    chk(grantValid === 1'b1 && grantIdx == 4'd1, "R6 held without done", int'(grantIdx), 1);
    serveOne(1, "R5 first");
    serveOne(5, "R5 second");
    serveOne(9, "R5 third");
    serveOne(1, "R7 held request");
    chk(grantValid === 1'b0, "R7 queue empty", int'(grantValid), 0);
    pulse(16'h8001);  // pointer at 2: 15 then wrap to 0
    @(negedge clk);
    serveOne(15, "R5 before wrap");
    serveOne(0, "R5 wrap");

    // R8 link merge and link alone
    doReset();
    prioIn = 32'h5555_5555;
    linkValid = 1'b1; linkTarget = 4'd6;
    pulse(16'h0040);
    linkValid = 1'b0;
    @(negedge clk);
    serveOne(6, "R8 merged");
    chk(grantValid === 1'b0, "R8 served once", int'(grantValid), 0);
    linkValid = 1'b1; linkTarget = 4'd12;
    @(negedge clk);
    linkValid = 1'b0;
    @(negedge clk);
    serveOne(12, "R8 link alone");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule